// File: doc/BRIEF.md
# SDRAM Burst Sequencing Engine

This block is the column-burst control of a synchronous DRAM, seen from the device side. A mode-load command stores three settings: the read latency (2 or 3 clocks), the burst length (1, 2, 4, 8 or a whole 512-column row), and the address order (linear wrap or XOR interleave). Read and write commands carry a bank and a starting column. From the next cycle on, the engine presents one column per cycle until the burst runs out. A stop command ends a burst early. A new read or write replaces the running burst on any cycle.

Read beats go through a latency pipeline. The engine raises a read-valid strobe, with the matching column and bank, exactly the programmed number of clocks after the read command. For writes it gives a per-beat write strobe. The data mask input blocks that strobe in the same cycle. For reads the same mask input is delayed by two cycles. The memory array, refresh, row timing and pin electrical behaviour live outside the block.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, no beat, read-valid, mask or error output is asserted. The mode is read latency 2, linear order, burst length 1.
- R2: A mode-load command (cmd 1) issued while the engine is idle takes `mode_i` from the next cycle on. `mode_i` bit 4 selects latency 3 (0 means 2), bit 3 selects interleave, and bits 2:0 hold the length code: 0..3 give lengths 1, 2, 4 and 8, and 4 gives a full row.
- R3: A mode-load is ignored when a burst is running or read beats are still in the latency pipeline. In that case `mode_err_o` is high for exactly the next cycle.
- R4: In linear order with length N (1..8), a read (cmd 2) or write (cmd 3) produces N beats, starting the cycle after the command. Beat k shows column (start + k) mod N inside the N-aligned block that holds the start column, and the burst then ends.
- R5: In linear order with the full-row code, the column counts up from the start and wraps from 511 to 0. This continues until a stop or a new burst.
- R6: In interleave order, beat k shows the start column with its low log2(N) bits XORed with k.
- R7: A read or write with interleave and the full-row code, or with length code 5..7, starts nothing. `burst_err_o` is high for the next cycle, and any running burst continues unchanged.
- R8: After a stop command (cmd 4), `beat_valid_o` is low from the next cycle on, until a new burst starts.
- R9: A read or write accepted during a running burst abandons it. The next cycle shows beat 0 of the new burst, with its own column and direction.
- R10: A read beat shown in cycle t gives `rd_valid_o` in cycle t+L-1 together with its column. So the first beat's data is valid L cycles after the read command.
- R11: `rd_mask_o` in a cycle equals the value `dqm_i` had two cycles before.
- R12: `wr_strobe_o` is high only in a write beat cycle in which `dqm_i` is low in that same cycle.
- R13: The bank given with each accepted read or write is held on `beat_bank_o` for all of its beats, and on `rd_bank_o` with its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | 0 idle, 1 mode load, 2 read, 3 write, 4 stop |
| bank_i | input | 2 | Bank for a read or write |
| col_i | input | 9 | Start column for a read or write |
| mode_i | input | 5 | Mode value for a mode load |
| dqm_i | input | 1 | Data mask |
| beat_valid_o | output | 1 | A burst beat is presented this cycle |
| beat_col_o | output | 9 | Column of the current beat |
| beat_bank_o | output | 2 | Bank of the current beat |
| beat_write_o | output | 1 | Current beat belongs to a write |
| wr_strobe_o | output | 1 | Unmasked write beat |
| rd_valid_o | output | 1 | Read data valid after latency |
| rd_col_o | output | 9 | Column of the read data beat |
| rd_bank_o | output | 2 | Bank of the read data beat |
| rd_mask_o | output | 1 | Read data beat is masked |
| mode_err_o | output | 1 | Mode load refused while busy |
| burst_err_o | output | 1 | Illegal burst request refused |

## Verification
The hardest case to reach is a mode load that arrives while read beats are still draining through the latency pipeline after the burst has ended. There the burst counter is idle but the engine still counts as busy. A directed sequence loads latency 3 with length 8, issues a read, and tries a mode load on its second beat. A later read then shows that the latency did not change. Random command streams with frequent mode loads and stops, replacements on arbitrary beats and illegal length codes then reach the drain-window and replacement-on-last-beat cases many times. A cycle model in the bench is compared on every cycle.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_MODE  = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_STOP  = 3'd4
  } sbe_cmd_e;

  // mode word: [4] latency 3, [3] interleave, [2:0] length code
  typedef struct packed {
    logic       lat3;
    logic       intl;
    logic [2:0] len_code;
  } sbe_mode_t;

  localparam logic [2:0] LEN_FULL = 3'd4;

  function automatic logic mode_legal(input sbe_mode_t m);
    return (m.len_code < LEN_FULL) || ((m.len_code == LEN_FULL) && !m.intl);
  endfunction

endpackage

// File: rtl/sbe_mode_reg.sv
module sbe_mode_reg
  import sbe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  logic      busy_i,
  input  sbe_mode_t mode_i,
  output sbe_mode_t mode_o,
  output logic      err_o
);

  sbe_mode_t mode_q, mode_d;
  logic      err_q, err_d;
  logic      mode_en;

  assign mode_en = load_i && !busy_i;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = mode_i;
    err_d = load_i && busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      err_q <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  // R2: idle load takes effect next cycle
  assert_idle_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_i) |=> (mode_o == $past(mode_i)));

  // R3: busy load leaves mode untouched and flags
  assert_busy_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy_i) |=> ($stable(mode_o) && err_o));

endmodule

// File: rtl/sbe_burst_ctrl.sv
module sbe_burst_ctrl
  import sbe_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              start_wr_i,
  input  logic              stop_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  sbe_mode_t         mode_i,
  output logic              beat_valid_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic              beat_write_o,
  output logic              err_o
);

  logic              act_q, act_d;
  logic [COL_W-1:0]  cnt_q, cnt_d;
  logic [COL_W-1:0]  start_q, start_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              wr_q, wr_d;
  logic              err_q, err_d;

  logic              legal;
  logic              full;
  logic              last;
  logic              accept;
  logic [COL_W-1:0]  len_mask;

  assign legal    = mode_legal(mode_i);
  assign full     = (mode_i.len_code == LEN_FULL);
  assign len_mask = full ? '1 : ((COL_W'(1) << mode_i.len_code) - COL_W'(1));
  assign last     = !full && (cnt_q == len_mask);
  assign accept   = start_i && legal;

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    bank_d  = bank_q;
    wr_d    = wr_q;
    err_d   = 1'b0;
    if (accept) begin
      act_d   = 1'b1;
      cnt_d   = '0;
      start_d = col_i;
      bank_d  = bank_i;
      wr_d    = start_wr_i;
    end else if (stop_i) begin
      act_d = 1'b0;
    end else begin
      err_d = start_i;
      if (act_q) begin
        if (last) act_d = 1'b0;
        else      cnt_d = cnt_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      start_q <= '0;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      err_q <= err_d;
      if (accept || act_q) cnt_q <= cnt_d;
      if (accept) begin
        start_q <= start_d;
        bank_q  <= bank_d;
        wr_q    <= wr_d;
      end
    end
  end

  // beat column from start and beat count
  always_comb begin
    if (full)
      beat_col_o = start_q + cnt_q;
    else if (mode_i.intl)
      beat_col_o = start_q ^ (cnt_q & len_mask);
    else
      beat_col_o = (start_q & ~len_mask) | ((start_q + cnt_q) & len_mask);
  end

  assign beat_valid_o = act_q;
  assign beat_bank_o  = bank_q;
  assign beat_write_o = wr_q;
  assign err_o        = err_q;

  // R9 / R13: accepted burst shows its own column and bank next cycle
  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (beat_valid_o && beat_col_o == $past(col_i) && beat_bank_o == $past(bank_i)));

  // R8: stop ends the burst
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !beat_valid_o);

  // R7: illegal request on an idle engine starts nothing
  assert_illegal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !legal && !act_q) |=> (!beat_valid_o && err_o));

  // R4: linear short bursts stay inside the aligned block
  assert_block_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !full && !mode_i.intl) |-> ((beat_col_o & ~len_mask) == (start_q & ~len_mask)));

endmodule

// File: rtl/sbe_read_pipe.sv
module sbe_read_pipe #(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [COL_W-1:0]  in_col_i,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic              lat3_i,
  input  logic              dqm_i,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic              rd_mask_o,
  output logic              pending_o
);

  localparam int STG      = MAX_LAT - 1;
  localparam int MASK_DLY = 2;

  logic [STG-1:0]    sv_q, sv_d;
  logic [COL_W-1:0]  sc_q [STG];
  logic [COL_W-1:0]  sc_d [STG];
  logic [BANK_W-1:0] sb_q [STG];
  logic [BANK_W-1:0] sb_d [STG];
  logic [MASK_DLY-1:0] msk_q, msk_d;
  int unsigned       tap;

  for (genvar g = 0; g < STG; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        sv_d[g] = in_valid_i;
        sc_d[g] = in_col_i;
        sb_d[g] = in_bank_i;
      end
    end else begin : g_tail
      always_comb begin
        sv_d[g] = sv_q[g-1];
        sc_d[g] = sc_q[g-1];
        sb_d[g] = sb_q[g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv_q[g] <= 1'b0;
        sc_q[g] <= '0;
        sb_q[g] <= '0;
      end else begin
        sv_q[g] <= sv_d[g];
        if (sv_d[g]) begin
          sc_q[g] <= sc_d[g];
          sb_q[g] <= sb_d[g];
        end
      end
    end
  end

  assign msk_d = {msk_q[MASK_DLY-2:0], dqm_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msk_q <= '0;
    else        msk_q <= msk_d;
  end

  assign tap        = lat3_i ? (STG - 1) : (STG - 2);
  assign rd_valid_o = sv_q[tap];
  assign rd_col_o   = sc_q[tap];
  assign rd_bank_o  = sb_q[tap];
  assign rd_mask_o  = msk_q[MASK_DLY-1];
  assign pending_o  = |sv_q;

  // cycles since reset, for the two-deep look-backs below
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  // R11: read mask follows data mask by two cycles
  assert_mask_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (rd_mask_o == $past(dqm_i, 2)));

  // R10: latency 2 read data one cycle behind its beat
  assert_lat2_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat3_i && rd_valid_o) |-> ($past(in_valid_i) && rd_col_o == $past(in_col_i)));

  // R10: latency 3 read data two cycles behind its beat
  assert_lat3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat3_i && rd_valid_o && age_q == 2'd2) |-> ($past(in_valid_i, 2) && rd_col_o == $past(in_col_i, 2)));

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sbe_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [4:0]        mode_i,
  input  logic              dqm_i,
  output logic              beat_valid_o,
  output logic [COL_W-1:0]  beat_col_o,
  output logic [BANK_W-1:0] beat_bank_o,
  output logic              beat_write_o,
  output logic              wr_strobe_o,
  output logic              rd_valid_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic              rd_mask_o,
  output logic              mode_err_o,
  output logic              burst_err_o
);

  sbe_cmd_e  cmd;
  sbe_mode_t mode_cur;
  logic      is_start, is_write, is_stop, is_load;
  logic      busy, pending;

  assign cmd      = sbe_cmd_e'(cmd_i);
  assign is_write = (cmd == CMD_WRITE);
  assign is_start = (cmd == CMD_READ) || is_write;
  assign is_stop  = (cmd == CMD_STOP);
  assign is_load  = (cmd == CMD_MODE);
  assign busy     = beat_valid_o || pending;

  sbe_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (is_load),
    .busy_i (busy),
    .mode_i (sbe_mode_t'(mode_i)),
    .mode_o (mode_cur),
    .err_o  (mode_err_o)
  );

  sbe_burst_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (is_start),
    .start_wr_i   (is_write),
    .stop_i       (is_stop),
    .col_i        (col_i),
    .bank_i       (bank_i),
    .mode_i       (mode_cur),
    .beat_valid_o (beat_valid_o),
    .beat_col_o   (beat_col_o),
    .beat_bank_o  (beat_bank_o),
    .beat_write_o (beat_write_o),
    .err_o        (burst_err_o)
  );

  sbe_read_pipe #(.COL_W(COL_W), .BANK_W(BANK_W), .MAX_LAT(MAX_LAT)) u_rpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (beat_valid_o && !beat_write_o),
    .in_col_i   (beat_col_o),
    .in_bank_i  (beat_bank_o),
    .lat3_i     (mode_cur.lat3),
    .dqm_i      (dqm_i),
    .rd_valid_o (rd_valid_o),
    .rd_col_o   (rd_col_o),
    .rd_bank_o  (rd_bank_o),
    .rd_mask_o  (rd_mask_o),
    .pending_o  (pending)
  );

  assign wr_strobe_o = beat_valid_o && beat_write_o && !dqm_i;

endmodule

// File: tb/sdram_burst_engine_tb_top.sv
module sdram_burst_engine_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd_i;
  logic [1:0] bank_i;
  logic [8:0] col_i;
  logic [4:0] mode_i;
  logic       dqm_i;
  logic       beat_valid_o, beat_write_o, wr_strobe_o, rd_valid_o, rd_mask_o;
  logic       mode_err_o, burst_err_o;
  logic [8:0] beat_col_o, rd_col_o;
  logic [1:0] beat_bank_o, rd_bank_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  sdram_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
    .mode_i(mode_i), .dqm_i(dqm_i), .beat_valid_o(beat_valid_o),
    .beat_col_o(beat_col_o), .beat_bank_o(beat_bank_o), .beat_write_o(beat_write_o),
    .wr_strobe_o(wr_strobe_o), .rd_valid_o(rd_valid_o), .rd_col_o(rd_col_o),
    .rd_bank_o(rd_bank_o), .rd_mask_o(rd_mask_o), .mode_err_o(mode_err_o),
    .burst_err_o(burst_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference state
  logic       m_lat3, m_intl, m_act, m_wr, m_merr, m_berr, m_d1, m_d2;
  logic [2:0] m_code;
  logic [8:0] m_cnt, m_start, mc0, mc1, cur_m;
  logic [1:0] m_bank, mb0, mb1, mv;
  logic       busy_m;

  function automatic logic [8:0] exp_col(logic [8:0] st, logic [8:0] c, logic [2:0] code, logic intl);
    logic [8:0] m;
    if (code == 3'd4) return st + c;
    m = (9'd1 << code) - 9'd1;
    if (intl) return st ^ (c & m);
    return (st & ~m) | ((st + c) & m);
  endfunction

  function automatic logic legal(logic [2:0] code, logic intl);
    return (code < 3'd4) || (code == 3'd4 && !intl);
  endfunction

  task automatic advance();
    if (m_act) begin
      if (m_code != 3'd4 && m_cnt == ((9'd1 << m_code) - 9'd1)) m_act = 1'b0;
      else m_cnt = m_cnt + 9'd1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat3 = 0; m_intl = 0; m_code = 0; m_act = 0; m_wr = 0; m_cnt = 0;
      m_start = 0; m_bank = 0; mv = 0; mc0 = 0; mc1 = 0; mb0 = 0; mb1 = 0;
      m_d1 = 0; m_d2 = 0; m_merr = 0; m_berr = 0;
    end else begin
      busy_m = m_act || (mv != 2'b00);
      cur_m  = exp_col(m_start, m_cnt, m_code, m_intl);
      mv[1] = mv[0]; mc1 = mc0; mb1 = mb0;
      mv[0] = m_act && !m_wr; mc0 = cur_m; mb0 = m_bank;
      m_d2 = m_d1; m_d1 = dqm_i;
      m_merr = 0; m_berr = 0;
      if (cmd_i == 3'd1) begin
        if (busy_m) m_merr = 1'b1;
        else {m_lat3, m_intl, m_code} = mode_i;
        advance();
      end else if ((cmd_i == 3'd2 || cmd_i == 3'd3) && legal(m_code, m_intl)) begin
        m_act = 1'b1; m_cnt = 0; m_start = col_i; m_bank = bank_i; m_wr = (cmd_i == 3'd3);
      end else if (cmd_i == 3'd4) begin
        m_act = 1'b0;
      end else begin
        if (cmd_i == 3'd2 || cmd_i == 3'd3) m_berr = 1'b1;
        advance();
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    string ctag;
    logic  erv;
    ctag = (m_code == 3'd4) ? "R5" : (m_intl ? "R6" : "R4");
    chk("R8 beat_valid", beat_valid_o, m_act);
    if (m_act) begin
      chk({ctag, " beat_col"}, beat_col_o, exp_col(m_start, m_cnt, m_code, m_intl));
      chk("R13 beat_bank", beat_bank_o, m_bank);
      chk("R9 beat_write", beat_write_o, m_wr);
    end
    chk("R12 wr_strobe", wr_strobe_o, m_act && m_wr && !dqm_i);
    erv = m_lat3 ? mv[1] : mv[0];
    chk("R10 rd_valid", rd_valid_o, erv);
    if (erv) begin
      chk("R10 rd_col", rd_col_o, m_lat3 ? mc1 : mc0);
      chk("R13 rd_bank", rd_bank_o, m_lat3 ? mb1 : mb0);
    end
    chk("R11 rd_mask", rd_mask_o, m_d2);
    chk("R3 mode_err", mode_err_o, m_merr);
    chk("R7 burst_err", burst_err_o, m_berr);
  endtask

  task automatic cycle(input logic [2:0] c, input logic [1:0] b, input logic [8:0] col,
                       input logic [4:0] md, input logic dq);
    @(negedge clk);
    compare_all();
    cmd_i = c; bank_i = b; col_i = col; mode_i = md; dqm_i = dq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(3'd0, 2'd0, 9'd0, 5'd0, 1'b0);
  endtask

  task automatic nop();
    cycle(3'd0, 2'd0, 9'd0, 5'd0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    rst_n = 0; cmd_i = 0; bank_i = 0; col_i = 0; mode_i = 0; dqm_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 beat_valid", beat_valid_o, 0);
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 rd_mask", rd_mask_o, 0);
    chk("R1 errors", {mode_err_o, burst_err_o}, 0);

    // R1: default mode, length 1 latency 2
    cycle(3'd2, 2'd1, 9'd33, 5'd0, 1'b0);
    nop(); #1 chk("R1 first col", beat_col_o, 33);
    nop(); #1 chk("R1 single beat", beat_valid_o, 0);
    chk("R1 lat2 valid", rd_valid_o, 1);
    chk("R1 lat2 col", rd_col_o, 33);
    idle(4);

    // R4: linear length 4 from 6 -> 6 7 4 5
    cycle(3'd1, 2'd0, 9'd0, 5'b00010, 1'b0);
    cycle(3'd2, 2'd0, 9'd6, 5'd0, 1'b0);
    nop(); nop(); nop(); #1 chk("R4 wrap col", beat_col_o, 4);
    nop(); nop(); #1 chk("R4 end", beat_valid_o, 0);
    idle(4);

    // R2: latency 3 length 8
    cycle(3'd1, 2'd0, 9'd0, 5'b10011, 1'b0);
    cycle(3'd2, 2'd3, 9'd5, 5'd0, 1'b0);
    nop(); nop(); #1 chk("R2 not yet", rd_valid_o, 0);
    nop(); #1 chk("R2 lat3 valid", rd_valid_o, 1);
    chk("R2 lat3 col", rd_col_o, 5);
    idle(12);

    // R3: load refused while busy, latency kept
    cycle(3'd2, 2'd0, 9'd0, 5'd0, 1'b0);
    nop();
    cycle(3'd1, 2'd0, 9'd0, 5'b00000, 1'b0);
    nop(); #1 chk("R3 err flag", mode_err_o, 1);
    idle(14);
    cycle(3'd2, 2'd0, 9'd40, 5'd0, 1'b0);
    nop(); nop(); nop(); #1 chk("R3 latency kept", rd_valid_o, 1);
    idle(12);

    // R5: full row linear from 510
    cycle(3'd1, 2'd0, 9'd0, 5'b00100, 1'b0);
    cycle(3'd3, 2'd1, 9'd510, 5'd0, 1'b0);
    nop(); nop(); nop(); #1 chk("R5 row wrap", beat_col_o, 0);
    cycle(3'd4, 2'd0, 9'd0, 5'd0, 1'b0);
    nop(); #1 chk("R8 stopped", beat_valid_o, 0);
    idle(4);

    // R6: interleave length 8 from 13 -> 13 12 15 ...
    cycle(3'd1, 2'd0, 9'd0, 5'b01011, 1'b0);
    cycle(3'd2, 2'd0, 9'd13, 5'd0, 1'b0);
    nop(); nop(); nop(); #1 chk("R6 xor col", beat_col_o, 15);
    idle(10);

    // R7: interleave with full row refused
    cycle(3'd1, 2'd0, 9'd0, 5'b01100, 1'b0);
    cycle(3'd2, 2'd0, 9'd7, 5'd0, 1'b0);
    nop(); #1 chk("R7 err flag", burst_err_o, 1);
    chk("R7 no beat", beat_valid_o, 0);
    idle(3);

    // R9 / R13 / R12: replace a read by a write, then mask a beat
    cycle(3'd1, 2'd0, 9'd0, 5'b00011, 1'b0);
    cycle(3'd2, 2'd0, 9'd0, 5'd0, 1'b0);
    nop(); nop();
    cycle(3'd3, 2'd2, 9'd100, 5'd0, 1'b0);
    nop(); #1 chk("R9 new col", beat_col_o, 100);
    chk("R9 new dir", beat_write_o, 1);
    chk("R13 new bank", beat_bank_o, 2);
    cycle(3'd0, 2'd0, 9'd0, 5'd0, 1'b1); #1 chk("R12 masked", wr_strobe_o, 0);
    nop(); #1 chk("R12 unmasked", wr_strobe_o, 1);
    cycle(3'd4, 2'd0, 9'd0, 5'd0, 1'b0);
    idle(6);

    // random mix
    r = $urandom(32'h1D5E);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      r = $urandom_range(0, 99);
      if      (r < 55) c = 3'd0;
      else if (r < 65) c = 3'd1;
      else if (r < 78) c = 3'd2;
      else if (r < 90) c = 3'd3;
      else             c = 3'd4;
      cycle(c, 2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)),
            5'($urandom_range(0, 31)), ($urandom_range(0, 3) == 0));
    end
    idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule